// File: doc/BRIEF.md
# Interrupt Input Trigger Conditioner

This block sits between raw interrupt pins and an interrupt controller. Each of its lines takes one asynchronous pin and brings it into the clock domain through a two-flop synchronizer. It then turns the pin into a request according to that line's configuration. In level mode the request follows the pin's active level. In edge mode one transition latches the request. In hybrid mode an edge counts only when the new level then holds for a programmable number of cycles. Hybrid mode is meant for inputs such as a non-maskable interrupt, where a short burst of noise must not become a request.

The controller sees one request bit per line. In edge and hybrid modes it drops the latched request by pulsing that line's clear input once the interrupt is serviced. In level mode the device itself withdraws the request by releasing the pin. Priority, masking and register access belong to the controller.

Top module: `irq_trigger_cond`

## Requirements
- R1: While reset is held and for the first three clock edges after it is released, every request output is low. After that, a level-mode request follows a change of the pin two clock edges later.
- R2: In level mode (mode code 00) the request is high exactly while the synchronized pin is at its active level. The polarity bit selects the active level: 0 means high is active, 1 means low is active. The request falls two edges after the pin leaves the active level.
- R3: In level mode the clear input has no effect on the request.
- R4: In edge mode (mode code 01) a transition into the active level latches the request. Polarity 0 selects a rising edge and polarity 1 a falling edge. The request appears three edges after the pin changes and stays high after the pin returns to idle.
- R5: A latched request in edge or hybrid mode holds until clear is sampled high, and it is low from the following cycle. If a new qualifying edge arrives in the same cycle as clear, the request stays set.
- R6: A pin that is already at its active level when reset is released does not count as an edge.
- R7: In hybrid mode (mode code 10) the request is latched only after the synchronized pin has been active for hold_cycles consecutive samples, counting the edge sample. The request appears hold_cycles+2 edges after the pin changes. A shorter pulse is rejected.
- R8: In hybrid mode, if the pin leaves the active level before the count completes, the count is discarded and a fresh edge is needed to start again.
- R9: In hybrid mode a hold_cycles value of 0 or 1 behaves exactly like edge mode.
- R10: Mode code 11 switches a line off. Its request is low and any latched request or partial count is discarded.
- R11: Lines are independent. Activity on one line never raises another line's request.
- R12: The two mode bits of line i are trig_mode_i[2i+1:2i]. hold_cycles_i is shared by all lines and is 16 bits wide by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_raw_i | input | NUM_LINES | Raw asynchronous interrupt pins |
| trig_mode_i | input | 2*NUM_LINES | Per-line mode: 00 level, 01 edge, 10 hybrid, 11 off |
| polarity_i | input | NUM_LINES | Per-line polarity: 0 high/rising, 1 low/falling |
| hold_cycles_i | input | CNT_W | Hybrid minimum active time in clock cycles |
| clear_i | input | NUM_LINES | Per-line service acknowledge that drops a latched request |
| req_o | output | NUM_LINES | Conditioned request to the controller |

## Verification
A wrong internal state on this block shows up at the ports as a change in request timing.

- A wrong synchronizer depth or warm-up count moves the first request by a cycle. It can also let a request through during the three post-reset cycles.
- A stale history bit makes a line that was already active at reset look like an edge. That request appears on the third edge after reset.
- A hold counter that fails to restart, or is off by one, accepts a pulse one sample too short. It can also delay the request by exactly one cycle, so the bench measures latency to the cycle and sweeps pulse width against hold time.
- A latch that ignores clear, or that clears over a same-cycle edge, is visible on the request one cycle after the clear pulse.

// File: rtl/irq_cond_pkg.sv
// Package: shared types for the interrupt trigger conditioner.
// Assumes: mode codes are fixed by the port encoding given in the brief.
package irq_cond_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'b00,
        TRIG_EDGE   = 2'b01,
        TRIG_HYBRID = 2'b10,
        TRIG_OFF    = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/irq_sync_chain.sv
// Module: irq_sync_chain
// Brings one asynchronous pin into the clock domain through STAGES flops.
// It also reports "primed" once the chain and one history sample downstream
// hold real pin samples instead of reset values.
// Assumes: STAGES >= 2; reset is synchronous and active low.
module irq_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic primed_o
);
    localparam int FILL_MAX = STAGES + 1;
    localparam int FW       = $clog2(FILL_MAX + 1);

    logic [STAGES-1:0] chain;
    logic [FW-1:0]     fill;

    // Shift the raw pin through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], raw_i};
    end

    // Count edges since reset until the chain plus history are filled.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fill <= '0;
        else if (fill != FW'(FILL_MAX))  fill <= fill + FW'(1);
    end

    assign sync_o   = chain[STAGES-1];
    assign primed_o = (fill == FW'(FILL_MAX));

    // R1
    primed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_o |=> primed_o);

endmodule

// File: rtl/irq_hold_timer.sv
// Module: irq_hold_timer
// Hybrid-mode qualifier. A start pulse (the edge sample) arms the timer.
// Each further active sample extends the count. "fire" pulses in the cycle
// where the count of consecutive active samples reaches the limit. Any
// inactive sample while armed drops the count.
// Assumes: start only occurs on an active sample; the limit is stable while armed.
module irq_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             armed;
    logic             step;

    // Work out the count this sample would reach and whether it qualifies.
    always_comb begin
        next_cnt = start_i ? CNT_W'(1) : cnt + CNT_W'(1);
        step     = enable_i && (start_i || (armed && active_i));
        fire_o   = step && (next_cnt >= limit_i);
    end

    // Track the armed state and the run length of active samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (fire_o) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (step) begin
            armed <= 1'b1;
            cnt   <= next_cnt;
        end else if (armed && !active_i) begin
            armed <= 1'b0;
            cnt   <= '0;
        end
    end

    // R7
    arm_starts_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> (cnt == CNT_W'(1)));

    // R8
    drop_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !active_i && !start_i) |=> !armed);

endmodule

// File: rtl/irq_line_cond.sv
// Module: irq_line_cond
// Trigger logic for one synchronized line. It normalizes polarity, detects
// the edge into the active level, and produces the request for the selected
// mode: level (follows the pin), edge (latched), hybrid (latched after the
// hold timer qualifies) or off.
// Assumes: sync_i is already synchronized; primed_i gates the history bit.
module irq_line_cond
    import irq_cond_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             primed_i,
    input  trig_mode_e       mode_i,
    input  logic             pol_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             req_o
);
    logic act;
    logic act_prev;
    logic edge_now;
    logic hyb_fire;
    logic set_now;
    logic pend;

    assign act      = sync_i ^ pol_i;
    assign edge_now = primed_i && act && !act_prev;

    // Remember the previous normalized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_prev <= 1'b0;
        else        act_prev <= act;
    end

    irq_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (mode_i == TRIG_HYBRID),
        .start_i  (edge_now),
        .active_i (act),
        .limit_i  (limit_i),
        .fire_o   (hyb_fire)
    );

    // Choose the event that latches a request in the current mode.
    always_comb begin
        case (mode_i)
            TRIG_EDGE:   set_now = edge_now;
            TRIG_HYBRID: set_now = hyb_fire;
            default:     set_now = 1'b0;
        endcase
    end

    // Hold the latched request until cleared; a new event beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_i == TRIG_LEVEL || mode_i == TRIG_OFF) pend <= 1'b0;
        else pend <= set_now || (pend && !clear_i);
    end

    // Drive the request from the level or from the latch.
    always_comb begin
        case (mode_i)
            TRIG_LEVEL: req_o = primed_i && act;
            TRIG_OFF:   req_o = 1'b0;
            default:    req_o = pend;
        endcase
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clear_i && (mode_i == TRIG_EDGE || mode_i == TRIG_HYBRID)) |=> pend);

    // R5
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clear_i && !edge_now && !hyb_fire) |=> !pend);

    // R10
    off_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_OFF) |=> !pend);

    // R7
    hybrid_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_HYBRID && $past(mode_i) == TRIG_HYBRID && $rose(pend))
        |-> $past(act));

endmodule

// File: rtl/irq_trigger_cond.sv
// Module: irq_trigger_cond (top)
// A bank of NUM_LINES independent interrupt input conditioners. Each line
// has its own synchronizer, mode, polarity and clear; the hybrid hold time
// is shared by all lines.
// Assumes: configuration changes only while the affected line is idle.
module irq_trigger_cond
    import irq_cond_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_raw_i,
    input  logic [2*NUM_LINES-1:0] trig_mode_i,
    input  logic [NUM_LINES-1:0]   polarity_i,
    input  logic [CNT_W-1:0]       hold_cycles_i,
    input  logic [NUM_LINES-1:0]   clear_i,
    output logic [NUM_LINES-1:0]   req_o
);
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] line_primed;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (irq_raw_i[i]),
            .sync_o   (line_sync[i]),
            .primed_o (line_primed[i])
        );

        irq_line_cond #(.CNT_W(CNT_W)) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (line_sync[i]),
            .primed_i (line_primed[i]),
            .mode_i   (trig_mode_e'(trig_mode_i[2*i +: 2])),
            .pol_i    (polarity_i[i]),
            .clear_i  (clear_i[i]),
            .limit_i  (hold_cycles_i),
            .req_o    (req_o[i])
        );

        // R1
        warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !line_primed[i] |-> !req_o[i]);
    end

endmodule

// File: tb/tb_irq_trigger_cond.sv
// Bench for irq_trigger_cond: directed latency sweeps per line, mode and
// polarity, plus a hybrid sweep of pulse width against hold time.
module tb_irq_trigger_cond;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   raw = '0;
    logic [2*N-1:0] mode = '1;
    logic [N-1:0]   pol = '0;
    logic [15:0]    hold = '0;
    logic [N-1:0]   clr = '0;
    logic [N-1:0]   req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_trigger_cond #(.NUM_LINES(N), .CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .irq_raw_i(raw), .trig_mode_i(mode),
        .polarity_i(pol), .hold_cycles_i(hold), .clear_i(clr), .req_o(req)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Switch every line off, drive idle levels, and let history settle.
    task automatic idle_all();
        mode = '1;
        clr  = '0;
        raw  = pol;
        tick(4);
    endtask

    // Measure the edges from a pin change to the first request.
    task automatic latency(int l, logic [1:0] m, int h, int expl, string tag);
        int lat = 0;
        idle_all();
        hold = 16'(h);
        mode[2*l +: 2] = m;
        tick(2);
        raw[l] = ~pol[l];
        for (int k = 1; k <= h + 6; k++) begin
            @(negedge clk);
            if (req[l] && lat == 0) lat = k;
        end
        check(tag, lat, expl);
        // R11: no other line follows this one
        check("R11 other lines quiet", int'(req & ~(N'(1) << l)), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 / R6: reset state and warm-up
        pol  = 4'b0110;
        raw  = 4'b0011;
        mode = {2'b11, 2'b00, 2'b01, 2'b01};
        tick(3);
        check("R1 req in reset", int'(req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 quiet after edge 1", int'(req), 0);
        @(negedge clk);
        check("R1 quiet after edge 2", int'(req), 0);
        @(negedge clk);
        check("R1 level active-low line after edge 3", int'(req[2]), 1);
        tick(5);
        check("R6 rising line high at reset", int'(req[0]), 0);
        check("R6 falling line idle high", int'(req[1]), 0);

        pol = '0;
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < N; l++) begin
                pol = '0;
                pol[l] = p[0];
                // R2: level latency and release
                latency(l, 2'b00, 0, 2, "R2 level latency");
                clr[l] = 1'b1;
                @(negedge clk);
                clr[l] = 1'b0;
                @(negedge clk);
                check("R3 clear ignored in level mode", int'(req[l]), 1);
                raw[l] = pol[l];
                @(negedge clk);
                check("R2 level still high one edge after release", int'(req[l]), 1);
                @(negedge clk);
                check("R2 level low two edges after release", int'(req[l]), 0);

                // R4: edge latency, latch survives release
                latency(l, 2'b01, 0, 3, "R4 edge latency");
                raw[l] = pol[l];
                tick(3);
                check("R4 edge latch after release", int'(req[l]), 1);
                // R5: clear drops it next cycle
                clr[l] = 1'b1;
                @(negedge clk);
                clr[l] = 1'b0;
                check("R5 clear drops latch", int'(req[l]), 0);
                // R5: edge coinciding with clear keeps the request
                raw[l] = ~pol[l];
                tick(3);
                raw[l] = pol[l];
                tick(3);
                raw[l] = ~pol[l];
                @(negedge clk);
                @(negedge clk);
                clr[l] = 1'b1;
                @(negedge clk);
                clr[l] = 1'b0;
                check("R5 edge beats clear", int'(req[l]), 1);

                // R7 / R9: hybrid latency
                for (int h = 0; h <= 5; h++) begin
                    latency(l, 2'b10, h, (h < 2) ? 3 : h + 2, "R7 R9 hybrid latency");
                end
                // R10: off discards the latch
                mode[2*l +: 2] = 2'b11;
                @(negedge clk);
                check("R10 off mode quiet", int'(req[l]), 0);
                mode[2*l +: 2] = 2'b10;
                @(negedge clk);
                check("R10 latch discarded", int'(req[l]), 0);
            end
        end

        // R7 / R9: pulse width against hold time on line 1
        pol = '0;
        for (int h = 0; h <= 6; h++) begin
            for (int w = 1; w <= 8; w++) begin
                idle_all();
                hold = 16'(h);
                mode[3:2] = 2'b10;
                tick(2);
                raw[1] = 1'b1;
                tick(w);
                raw[1] = 1'b0;
                tick(h + 4);
                check("R7 hybrid pulse width", int'(req[1]), (w >= ((h == 0) ? 1 : h)) ? 1 : 0);
            end
        end

        // R8: a one-cycle dropout restarts the count
        idle_all();
        hold = 16'd4;
        mode[1:0] = 2'b10;
        tick(2);
        raw[0] = 1'b1; tick(3);
        raw[0] = 1'b0; tick(1);
        raw[0] = 1'b1; tick(3);
        raw[0] = 1'b0; tick(8);
        check("R8 dropout restarts count", int'(req[0]), 0);

        // R12: mode field of line 3 sits in bits 7:6
        idle_all();
        mode[7:6] = 2'b00;
        raw[3] = 1'b1;
        tick(2);
        check("R12 line 3 mode field", int'(req), 8);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule